// File: doc/BRIEF.md
# Redundant Pair Re-execution Recovery Sequencer

This block runs the recovery sequence of a redundant core pair. The pair consists of a vocal core, whose results reach the system, and a mute core, which shadows it. Recovery starts when the pair's fingerprint comparator reports a mismatch. The sequencer first asks both cores to roll back to their last safe state and waits until each one confirms. It then holds both cores in single-step mode. Stepping continues until a core reports that the instruction it just stepped was a load or an atomic operation. That operation goes out to the request handler as a synchronizing request, so both cores receive the same coherent value. The comparator then checks the fingerprint that covers the stepped instructions.

If the comparison matches, at least one instruction has made progress. A one-cycle resume pulse then returns the pair to normal speculative execution.

If the first comparison fails, the sequencer starts a second phase. It streams the vocal register file into the mute core one register index per cycle and waits for the mute core to confirm the copy. It then repeats the single-step, synchronize and compare sequence. If the second comparison also fails, the sequencer enters a terminal state and raises an uncorrectable-error flag, which stays set until reset.

Top module: `reexec_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, every request output, `copy_valid_o`, `phase2_o`, `resume_o` and `uce_o` is 0.
- R2: When `mismatch_i` is seen in the idle state, `rollback_req_o` goes to 1 in the next cycle. It stays at 1 until both the vocal and the mute rollback-done pulses have been seen. The two pulses may arrive in different cycles, in either order.
- R3: After rollback, `step_req_o` stays at 1 through every step acknowledge that has `step_mem_i` = 0. An acknowledge that has `step_mem_i` = 1 drops `step_req_o` and raises `sync_req_o` in the next cycle.
- R4: `sync_req_o` stays at 1 until `sync_ack_i` is seen, and `cmp_req_o` goes to 1 in the following cycle.
- R5: A compare result with `cmp_match_i` = 1 produces `resume_o` = 1 for exactly one cycle. In that cycle the block is back in idle and `phase2_o` = 0.
- R6: A failed compare in the first phase sets `phase2_o` = 1 and starts the register copy. `copy_valid_o` is 1 for NREGS consecutive cycles, and `copy_idx_o` counts 0, 1, ..., NREGS-1 in those cycles.
- R7: `copy_done_i` has no effect until every index has been sent. After that, `copy_done_i` returns the block to stepping in the next cycle.
- R8: A failed compare in the second phase sets `uce_o` = 1 and drops every request output. This state stays unchanged whatever the inputs do, until reset.
- R9: `mismatch_i` has no effect while a recovery sequence is in progress.
- R10: At most one of `rollback_req_o`, `step_req_o`, `sync_req_o`, `cmp_req_o` and `copy_valid_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mismatch_i | input | 1 | Fingerprint mismatch from the comparator; starts recovery |
| rb_vocal_done_i | input | 1 | Vocal core has finished its rollback |
| rb_mute_done_i | input | 1 | Mute core has finished its rollback |
| rollback_req_o | output | 1 | Asks both cores to roll back to safe state |
| step_req_o | output | 1 | Asks both cores to execute one instruction non-speculatively |
| step_ack_i | input | 1 | One instruction has been stepped |
| step_mem_i | input | 1 | The stepped instruction was a load or an atomic operation |
| sync_req_o | output | 1 | Issues the memory operation as a synchronizing request |
| sync_ack_i | input | 1 | Coherent value has been delivered to both cores |
| cmp_req_o | output | 1 | Asks for comparison of the stepped-interval fingerprint |
| cmp_done_i | input | 1 | Comparison result is valid |
| cmp_match_i | input | 1 | Fingerprints matched |
| copy_valid_o | output | 1 | Register index on `copy_idx_o` is to be copied from vocal to mute |
| copy_idx_o | output | $clog2(NREGS) | Register index being copied |
| copy_done_i | input | 1 | Mute core confirms that the copy is complete |
| phase2_o | output | 1 | The second recovery phase is active |
| resume_o | output | 1 | One-cycle pulse: normal execution resumes |
| uce_o | output | 1 | Sticky uncorrectable-error flag |

## Verification
A table of recovery runs covers four things:
- The order and spacing of the two rollback confirmations.
- The number of non-memory instructions stepped before the load.
- A first-phase match.
- Both outcomes of the second phase.

These runs tell apart a sequencer that waits for only one core, one that stops stepping too early or too late, and one that confuses the success path with the copy path or the copy path with the failure path.

The copy runs hold `copy_done_i` high from their first cycle. This separates a sequencer that accepts the handshake early from one that finishes the full index sweep first.

Directed runs pulse `mismatch_i` in the middle of a recovery and drive every input while in the failure state. Together with the reset checks, they show which inputs the block must ignore.

// File: rtl/reexec_pkg.sv
// Package: types shared by the re-execution recovery sequencer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package reexec_pkg;

    // Recovery sequencer states.
    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_ROLLBACK = 3'd1,
        RS_STEP     = 3'd2,
        RS_SYNC     = 3'd3,
        RS_COMPARE  = 3'd4,
        RS_COPY     = 3'd5,
        RS_FAIL     = 3'd6
    } rcv_state_e;

endpackage

// File: rtl/reexec_regcopy.sv
// Module: register-file copy pacer. While enabled, it emits one register index
// per cycle from 0 to NREGS-1. It then waits for the mute core's completion
// handshake and reports when the copy is finished.
// Assumes: NREGS >= 2, and en_i stays high for the whole copy phase.
module reexec_regcopy #(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             copy_done_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             fin_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);

    logic [IDX_W-1:0] cnt_q;
    logic             sent_q;

    assign valid_o = en_i && !sent_q;
    assign idx_o   = cnt_q;
    assign fin_o   = en_i && sent_q && copy_done_i;

    // Advance the index once per cycle and mark when the last index has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            sent_q <= 1'b0;
        end else if (valid_o) begin
            if (cnt_q == LAST_IDX) begin
                sent_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != LAST_IDX) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

endmodule

// File: rtl/reexec_fsm.sv
// Module: recovery state machine. It captures both rollback confirmations,
// tracks whether the second phase is active, and drives the one-cycle resume pulse.
// Assumes: the handshake inputs are single-cycle pulses or levels that are
// sampled only in the state that waits for them.
module reexec_fsm
    import reexec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mismatch_i,
    input  logic       rb_vocal_done_i,
    input  logic       rb_mute_done_i,
    input  logic       step_ack_i,
    input  logic       step_mem_i,
    input  logic       sync_ack_i,
    input  logic       cmp_done_i,
    input  logic       cmp_match_i,
    input  logic       copy_fin_i,
    output rcv_state_e state_o,
    output logic       phase2_o,
    output logic       resume_o
);

    rcv_state_e state_q, state_d;
    logic       vocal_seen_q, mute_seen_q, both_rolled;
    logic       phase2_q, resume_q;

    assign both_rolled = (vocal_seen_q || rb_vocal_done_i) && (mute_seen_q || rb_mute_done_i);
    assign state_o     = state_q;
    assign phase2_o    = phase2_q;
    assign resume_o    = resume_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:     if (mismatch_i) state_d = RS_ROLLBACK;
            RS_ROLLBACK: if (both_rolled) state_d = RS_STEP;
            RS_STEP:     if (step_ack_i && step_mem_i) state_d = RS_SYNC;
            RS_SYNC:     if (sync_ack_i) state_d = RS_COMPARE;
            RS_COMPARE: begin
                if (cmp_done_i) begin
                    if (cmp_match_i)   state_d = RS_IDLE;
                    else if (phase2_q) state_d = RS_FAIL;
                    else               state_d = RS_COPY;
                end
            end
            RS_COPY:     if (copy_fin_i) state_d = RS_STEP;
            RS_FAIL:     state_d = RS_FAIL;
            default:     state_d = RS_FAIL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Hold each core's rollback confirmation until both have been seen.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != RS_ROLLBACK) begin
            vocal_seen_q <= 1'b0;
            mute_seen_q  <= 1'b0;
        end else begin
            vocal_seen_q <= vocal_seen_q || rb_vocal_done_i;
            mute_seen_q  <= mute_seen_q  || rb_mute_done_i;
        end
    end

    // Phase flag: set on the first failed compare, cleared on return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                   phase2_q <= 1'b0;
        else if (state_q == RS_COMPARE && cmp_done_i && !cmp_match_i) phase2_q <= 1'b1;
        else if (state_d == RS_IDLE)                                  phase2_q <= 1'b0;
    end

    // One-cycle resume pulse after a matching compare.
    always_ff @(posedge clk) begin
        if (!rst_n) resume_q <= 1'b0;
        else        resume_q <= (state_q == RS_COMPARE) && cmp_done_i && cmp_match_i;
    end

    // R2
    rollback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_ROLLBACK && !rb_vocal_done_i && !rb_mute_done_i) |=> (state_q == RS_ROLLBACK));

    // R4
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_SYNC && !sync_ack_i) |=> (state_q == RS_SYNC));

    // R5
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |=> !resume_q);

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FAIL) |=> (state_q == RS_FAIL && phase2_q));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_STEP && !step_ack_i) |=> (state_q == RS_STEP));

endmodule

// File: rtl/reexec_seq.sv
// Module: top level of the two-phase re-execution recovery sequencer. It decodes
// the state into the request handshakes and joins the state machine to the copy pacer.
// Assumes: the request outputs are levels, and each is held until its handshake returns.
module reexec_seq
    import reexec_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch_i,
    input  logic             rb_vocal_done_i,
    input  logic             rb_mute_done_i,
    output logic             rollback_req_o,
    output logic             step_req_o,
    input  logic             step_ack_i,
    input  logic             step_mem_i,
    output logic             sync_req_o,
    input  logic             sync_ack_i,
    output logic             cmp_req_o,
    input  logic             cmp_done_i,
    input  logic             cmp_match_i,
    output logic             copy_valid_o,
    output logic [IDX_W-1:0] copy_idx_o,
    input  logic             copy_done_i,
    output logic             phase2_o,
    output logic             resume_o,
    output logic             uce_o
);

    rcv_state_e state;
    logic       copy_fin;

    reexec_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .mismatch_i      (mismatch_i),
        .rb_vocal_done_i (rb_vocal_done_i),
        .rb_mute_done_i  (rb_mute_done_i),
        .step_ack_i      (step_ack_i),
        .step_mem_i      (step_mem_i),
        .sync_ack_i      (sync_ack_i),
        .cmp_done_i      (cmp_done_i),
        .cmp_match_i     (cmp_match_i),
        .copy_fin_i      (copy_fin),
        .state_o         (state),
        .phase2_o        (phase2_o),
        .resume_o        (resume_o)
    );

    reexec_regcopy #(.NREGS(NREGS)) u_copy (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (state == RS_COPY),
        .copy_done_i (copy_done_i),
        .valid_o     (copy_valid_o),
        .idx_o       (copy_idx_o),
        .fin_o       (copy_fin)
    );

    // Decode each state into its handshake request.
    always_comb begin
        rollback_req_o = (state == RS_ROLLBACK);
        step_req_o     = (state == RS_STEP);
        sync_req_o     = (state == RS_SYNC);
        cmp_req_o      = (state == RS_COMPARE);
        uce_o          = (state == RS_FAIL);
    end

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rollback_req_o, step_req_o, sync_req_o, cmp_req_o, copy_valid_o}));

    // R8
    uce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uce_o |=> (uce_o && !rollback_req_o && !step_req_o && !sync_req_o && !cmp_req_o && !copy_valid_o));

endmodule

// File: tb/reexec_seq_tb.sv
module reexec_seq_tb;

    localparam int NR = 8;
    localparam int IW = $clog2(NR);
    localparam int NV = 5;
    // Fields: vocal rollback delay[13:10], mute rollback delay[9:6],
    // non-memory steps[5:2], phase-1 match[1], phase-2 match[0].
    localparam logic [13:0] VEC [NV] = '{
        {4'd0, 4'd0, 4'd0, 1'b1, 1'b0},
        {4'd3, 4'd1, 4'd2, 1'b1, 1'b0},
        {4'd1, 4'd4, 4'd0, 1'b0, 1'b1},
        {4'd0, 4'd2, 4'd3, 1'b0, 1'b0},
        {4'd2, 4'd2, 4'd1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mismatch_i = 0, rb_vocal_done_i = 0, rb_mute_done_i = 0;
    logic step_ack_i = 0, step_mem_i = 0, sync_ack_i = 0;
    logic cmp_done_i = 0, cmp_match_i = 0, copy_done_i = 0;
    logic rollback_req_o, step_req_o, sync_req_o, cmp_req_o, copy_valid_o;
    logic [IW-1:0] copy_idx_o;
    logic phase2_o, resume_o, uce_o;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    reexec_seq #(.NREGS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .mismatch_i(mismatch_i),
        .rb_vocal_done_i(rb_vocal_done_i), .rb_mute_done_i(rb_mute_done_i),
        .rollback_req_o(rollback_req_o), .step_req_o(step_req_o),
        .step_ack_i(step_ack_i), .step_mem_i(step_mem_i),
        .sync_req_o(sync_req_o), .sync_ack_i(sync_ack_i),
        .cmp_req_o(cmp_req_o), .cmp_done_i(cmp_done_i), .cmp_match_i(cmp_match_i),
        .copy_valid_o(copy_valid_o), .copy_idx_o(copy_idx_o), .copy_done_i(copy_done_i),
        .phase2_o(phase2_o), .resume_o(resume_o), .uce_o(uce_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nx;
        @(negedge clk);
    endtask

    function automatic int reqs();
        return $countones({rollback_req_o, step_req_o, sync_req_o, cmp_req_o, copy_valid_o});
    endfunction

    task automatic do_reset;
        rst_n = 0;
        {mismatch_i, rb_vocal_done_i, rb_mute_done_i, step_ack_i, step_mem_i} = '0;
        {sync_ack_i, cmp_done_i, cmp_match_i, copy_done_i} = '0;
        nx; nx;
        chk("R1 outputs in reset", reqs() + phase2_o + resume_o + uce_o, 0);
        rst_n = 1;
        nx;
        chk("R1 outputs after reset", reqs() + phase2_o + resume_o + uce_o, 0);
    endtask

    // Start at a negedge in idle; leaves the bench at a negedge in the stepping state.
    task automatic start_rollback(input int vs, input int ms);
        int mx;
        mx = (vs > ms) ? vs : ms;
        mismatch_i = 1; nx; mismatch_i = 0;
        chk("R2 rollback_req raised", rollback_req_o, 1);
        for (int c = 0; c <= mx; c++) begin
            chk("R2 rollback_req held", rollback_req_o, 1);
            rb_vocal_done_i = (c == vs);
            rb_mute_done_i  = (c == ms);
            nx;
        end
        rb_vocal_done_i = 0; rb_mute_done_i = 0;
        chk("R2 rollback_req dropped", rollback_req_o, 0);
        chk("R3 step_req after rollback", step_req_o, 1);
    endtask

    // Runs step, sync and compare; leaves the bench at the negedge after the compare result.
    task automatic run_phase(input int n, input bit match);
        for (int i = 0; i <= n; i++) begin
            chk("R3 step_req held", step_req_o, 1);
            chk("R10 single request", reqs(), 1);
            step_ack_i = 1; step_mem_i = (i == n);
            nx;
        end
        step_ack_i = 0; step_mem_i = 0;
        chk("R3 step_req dropped", step_req_o, 0);
        chk("R3 sync_req raised", sync_req_o, 1);
        nx;
        chk("R4 sync_req held", sync_req_o, 1);
        sync_ack_i = 1; nx; sync_ack_i = 0;
        chk("R4 cmp_req raised", cmp_req_o, 1);
        chk("R4 sync_req dropped", sync_req_o, 0);
        cmp_done_i = 1; cmp_match_i = match; nx;
        cmp_done_i = 0; cmp_match_i = 0;
    endtask

    task automatic check_resume;
        chk("R5 resume pulse", resume_o, 1);
        chk("R5 idle at resume", reqs(), 0);
        chk("R5 phase2 cleared", phase2_o, 0);
        nx;
        chk("R5 resume single cycle", resume_o, 0);
    endtask

    task automatic run_copy;
        chk("R6 phase2 set", phase2_o, 1);
        copy_done_i = 1;
        for (int k = 0; k < NR; k++) begin
            chk("R6 copy_valid", copy_valid_o, 1);
            chk("R6 copy_idx", int'(copy_idx_o), k);
            nx;
        end
        chk("R7 copy_valid off after sweep", copy_valid_o, 0);
        chk("R7 not stepping before done accepted", step_req_o, 0);
        nx;
        copy_done_i = 0;
        chk("R7 step after copy done", step_req_o, 1);
    endtask

    task automatic check_fail;
        chk("R8 uce raised", uce_o, 1);
        chk("R8 requests dropped", reqs(), 0);
        {mismatch_i, rb_vocal_done_i, rb_mute_done_i, step_ack_i, step_mem_i} = '1;
        {sync_ack_i, cmp_done_i, cmp_match_i, copy_done_i} = '1;
        nx; nx; nx;
        chk("R8 uce sticky", uce_o, 1);
        chk("R8 requests stay low", reqs(), 0);
        chk("R8 no resume", resume_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset;
        // Table of recovery runs.
        for (int v = 0; v < NV; v++) begin
            start_rollback(int'(VEC[v][13:10]), int'(VEC[v][9:6]));
            run_phase(int'(VEC[v][5:2]), VEC[v][1]);
            if (VEC[v][1]) begin
                check_resume;
            end else begin
                run_copy;
                run_phase(int'(VEC[v][5:2]), VEC[v][0]);
                if (VEC[v][0]) check_resume;
                else begin
                    check_fail;
                    do_reset;
                end
            end
            nx;
        end
        // R9: a mismatch pulse during stepping and during the copy is ignored.
        start_rollback(0, 1);
        mismatch_i = 1; nx; mismatch_i = 0;
        chk("R9 still stepping", step_req_o, 1);
        chk("R9 no new rollback", rollback_req_o, 0);
        run_phase(0, 1'b0);
        mismatch_i = 1; nx; mismatch_i = 0;
        chk("R9 copy continues", int'(copy_idx_o), 1);
        chk("R9 phase2 kept", phase2_o, 1);
        copy_done_i = 1;
        repeat (NR) nx;
        copy_done_i = 0;
        chk("R9 back to stepping after copy", step_req_o, 1);
        run_phase(0, 1'b1);
        check_resume;
        // R1: reset taken from the middle of a recovery.
        mismatch_i = 1; nx; mismatch_i = 0;
        do_reset;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule